// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order address bits for a four-beat burst into a synchronous memory. A new access loads a full starting address. Each later advance cycle moves the low two bits to the next beat of the burst while the upper address bits stay fixed. A static order input picks the beat order. In interleaved order the start offset is XORed with the beat number. In linear order the start offset is incremented modulo four.

All inputs are sampled on the rising edge of one clock. A suspend input freezes the whole block: while it is high, load, advance and the order input are all ignored. The outputs are the registered beat offset and the full registered address, which is the captured upper bits joined to that offset. The burst length is two to the power `BEAT_W`, and `BEAT_W` defaults to 2. A build-time option can also strip out one of the two orders.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `addr_q` and `beat_ofs` to zero on the next rising edge. Reset takes priority over `stall`.
- R2: When `stall`=0 and `step`=0 at a rising edge, `addr_q` takes the value of `addr_in` from that edge. This restarts the beat number at 0.
- R3: With `ilv_mode`=1, after k advances since the load, `beat_ofs` equals (start offset XOR (k mod 4)).
- R4: With `ilv_mode`=0, after k advances since the load, `beat_ofs` equals ((start offset + k) mod 4).
- R5: An advance (`stall`=0, `step`=1) never changes `addr_q[ADDR_W-1:2]`.
- R6: The fifth beat equals the first: a burst that is advanced past its fourth beat wraps inside the same four-word group.
- R7: While `stall`=1, `addr_q` and `beat_ofs` hold their values, whatever is on `step`, `addr_in` or `ilv_mode`.
- R8: A change of `ilv_mode` does not change `beat_ofs` until the next advance. That advance applies the new order to the continued beat number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | 1 = suspend; every other synchronous input is ignored |
| step | input | 1 | 1 = advance one beat, 0 = load `addr_in` |
| ilv_mode | input | 1 | 1 = interleaved (XOR) order, 0 = linear (increment) order |
| addr_in | input | ADDR_W | External start address, captured on a load |
| addr_q | output | ADDR_W | Registered address: captured upper bits and current offset |
| beat_ofs | output | BEAT_W | Current burst offset |

## Verification
Some properties are checked by assertions on every cycle. Reset clears the outputs, a load captures the input address, and a suspend cycle holds the address. An advance leaves the upper bits alone and always moves the offset. The full beat orders need a scenario, and so do the wrap on the fifth beat and the delayed effect of a mode change. The bench sweeps every start offset, both orders and several upper-bit patterns. It then runs targeted suspend, mode-change and reset-priority scenarios.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_LOAD  = 2'd1,
      CMD_STEP  = 2'd2,
      CMD_CLEAR = 2'd3
   } cmd_e;

   // Order support options for the offset mapper
   localparam int ORDERS_BOTH       = 0;
   localparam int ORDERS_LINEAR     = 1;
   localparam int ORDERS_INTERLEAVE = 2;

   function automatic cmd_e decode_cmd(input logic rst_i, input logic stall_i,
                                       input logic step_i);
      if (rst_i)        return CMD_CLEAR;
      else if (stall_i) return CMD_HOLD;
      else if (step_i)  return CMD_STEP;
      else              return CMD_LOAD;
   endfunction

endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
   import burst_seq_pkg::*;
(
   input  logic rst,
   input  logic stall,
   input  logic step,
   input  logic ilv_mode,
   output cmd_e cmd,
   output order_e order
);

   always_comb begin
      cmd   = decode_cmd(rst, stall, step);
      order = ilv_mode ? ORD_INTERLEAVE : ORD_LINEAR;
   end

endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2,
   parameter int ORDERS = ORDERS_BOTH
)(
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   input  order_e            order,
   output logic [BEAT_W-1:0] ofs
);

   logic [BEAT_W-1:0] ofs_lin;
   logic [BEAT_W-1:0] ofs_ilv;

   // linear order: wrap-around increment from the start offset
   assign ofs_lin = start + beat;

   // interleaved order: bitwise toggle of the start by the beat number
   for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_ilv_bit
      assign ofs_ilv[gi] = start[gi] ^ beat[gi];
   end

   if (ORDERS == ORDERS_LINEAR) begin : g_lin_only
      assign ofs = ofs_lin;
   end else if (ORDERS == ORDERS_INTERLEAVE) begin : g_ilv_only
      assign ofs = ofs_ilv;
   end else begin : g_both
      assign ofs = (order == ORD_INTERLEAVE) ? ofs_ilv : ofs_lin;
   end

   if (ORDERS < ORDERS_BOTH || ORDERS > ORDERS_INTERLEAVE) begin : g_bad_orders
      $error("bsq_order_map: ORDERS out of range");
   end

endmodule

// File: rtl/bsq_state.sv
module bsq_state
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2,
   localparam int HI_W  = ADDR_W - BEAT_W
)(
   input  logic              clk,
   input  cmd_e              cmd,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BEAT_W-1:0] ofs_next,
   output logic [HI_W-1:0]   hi_q,
   output logic [BEAT_W-1:0] start_q,
   output logic [BEAT_W-1:0] beat_q,
   output logic [BEAT_W-1:0] beat_next,
   output logic [BEAT_W-1:0] ofs_q
);

   assign beat_next = beat_q + 1'b1;

   always_ff @(posedge clk) begin
      unique case (cmd)
         CMD_CLEAR: begin
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ofs_q   <= '0;
         end
         CMD_LOAD: begin
            hi_q    <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
            beat_q  <= '0;
            ofs_q   <= addr_in[BEAT_W-1:0];
         end
         CMD_STEP: begin
            beat_q  <= beat_next;
            ofs_q   <= ofs_next;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2,
   parameter int ORDERS = ORDERS_BOTH,
   localparam int HI_W  = ADDR_W - BEAT_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              stall,
   input  logic              step,
   input  logic              ilv_mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BEAT_W-1:0] beat_ofs
);

   if (BEAT_W < 1) begin : g_bad_beat
      $error("burst_addr_seq: BEAT_W must be at least 1");
   end
   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
   end

   cmd_e              cmd;
   order_e            order;
   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;
   logic [BEAT_W-1:0] beat_next;
   logic [BEAT_W-1:0] ofs_next;
   logic [BEAT_W-1:0] ofs_q;

   bsq_ctrl u_ctrl (
      .rst      (rst),
      .stall    (stall),
      .step     (step),
      .ilv_mode (ilv_mode),
      .cmd      (cmd),
      .order    (order)
   );

   bsq_order_map #(.BEAT_W(BEAT_W), .ORDERS(ORDERS)) u_map (
      .start (start_q),
      .beat  (beat_next),
      .order (order),
      .ofs   (ofs_next)
   );

   bsq_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
      .clk       (clk),
      .cmd       (cmd),
      .addr_in   (addr_in),
      .ofs_next  (ofs_next),
      .hi_q      (hi_q),
      .start_q   (start_q),
      .beat_q    (beat_q),
      .beat_next (beat_next),
      .ofs_q     (ofs_q)
   );

   assign addr_q   = {hi_q, ofs_q};
   assign beat_ofs = ofs_q;

   // R1: reset clears the outputs
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (addr_q == '0 && beat_ofs == '0));

   // R2: a load captures the external address
   p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
      (!stall && !step) |=> (addr_q == $past(addr_in)));

   // R7: suspend holds the address and offset
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(addr_q) && $stable(beat_ofs)));

   // R5: an advance leaves the upper address bits untouched
   p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
      (!stall && step) |=> (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W])));

   // R3 / R4: with an unchanged order, every advance moves to a new offset
   p_adv_moves_r3: assert property (@(posedge clk) disable iff (rst)
      (!stall && step && ilv_mode == $past(ilv_mode)) |=> !$stable(beat_ofs));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

   localparam int AW = 6;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          stall;
   logic          step;
   logic          ilv_mode;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_q;
   logic [BW-1:0] beat_ofs;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
      .clk(clk), .rst(rst), .stall(stall), .step(step),
      .ilv_mode(ilv_mode), .addr_in(addr_in),
      .addr_q(addr_q), .beat_ofs(beat_ofs)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // one clock edge, then settle away from the edge
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_ofs(input int s, input int k, input bit ilv);
      return ilv ? ((s ^ k) & 3) : ((s + k) & 3);
   endfunction

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; stall = 1'b0; step = 1'b0; ilv_mode = 1'b0; addr_in = '0;
      tick(); tick();
      check("R1 reset addr", int'(addr_q), 0);
      check("R1 reset ofs", int'(beat_ofs), 0);
      rst = 1'b0;

      // R2 R3 R4 R5 R6: sweep order, start offset, upper bits, six beats
      for (int m = 0; m < 2; m++) begin
         for (int hi = 0; hi < 16; hi += 5) begin
            for (int s = 0; s < 4; s++) begin
               ilv_mode = m[0];
               addr_in  = AW'((hi << 2) | s);
               step     = 1'b0;
               tick();
               check("R2 load", int'(addr_q), (hi << 2) | s);
               step    = 1'b1;
               addr_in = ~addr_in;
               for (int k = 1; k < 6; k++) begin
                  tick();
                  check(m ? "R3 interleaved" : "R4 linear", int'(beat_ofs),
                        exp_ofs(s, k, m[0]));
                  check("R5 upper bits", int'(addr_q) >> 2, hi);
                  if (k == 4) check("R6 wrap", int'(beat_ofs), s);
               end
            end
         end
      end

      // R7: suspend ignores loads, advances and order changes
      ilv_mode = 1'b0; step = 1'b0; addr_in = AW'(6'h29);
      tick();
      step = 1'b1;
      tick();                                 // offset 2
      stall = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step = i[0]; addr_in = AW'(i * 13); ilv_mode = i[1];
         tick();
         check("R7 hold addr", int'(addr_q), 6'h2a);
      end
      stall = 1'b0; ilv_mode = 1'b0; step = 1'b1;
      tick();
      check("R7 resume beat 2", int'(beat_ofs), 3);

      // R8: mode change during a burst
      step = 1'b0; addr_in = AW'(6'h11); ilv_mode = 1'b0;
      tick();
      step = 1'b1;
      tick();                                 // beat 1 linear: 2
      check("R8 before change", int'(beat_ofs), 2);
      stall = 1'b1; ilv_mode = 1'b1;
      tick();
      check("R8 no effect yet", int'(beat_ofs), 2);
      stall = 1'b0;
      tick();                                 // beat 2 interleaved: 1^2
      check("R8 new order", int'(beat_ofs), 3);

      // R1: reset wins over suspend
      stall = 1'b1; rst = 1'b1;
      tick();
      check("R1 reset over stall", int'(addr_q), 0);
      rst = 1'b0; stall = 1'b0;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule